// File: doc/BRIEF.md
# Shared-Memory Ring FIFO Client

This block moves bytes through circular buffers that live in another processor's memory. That memory is reached only through a bus-master port. To use it, the port is first requested and then granted. After that, single byte reads and writes are issued, each finished by an acknowledge. The port is then released.

Each ring has a three-byte descriptor placed directly below its base address. The lowest of the three bytes is the size mask, which equals the buffer length minus one. The next byte up is the producer (in) index, and the byte just below the base is the consumer (out) index. The block supports two independent channels. It keeps a local copy of each channel's base address, mask and indices.

A command port takes one operation at a time, with a valid/ready handshake. The operations are: bind a channel to a base (which loads its descriptor), test whether the ring is empty, test whether it is full, take a byte, and store a byte. Each command finishes with exactly one result pulse. Take and store keep polling until the ring allows them. Every poll and every transfer runs inside its own bus tenure.

Top module: `rfc_ring_client`

## Requirements
- R1: While `rst_n` is low and right after it rises: `cmd_ready` is 1, and `bus_req`, `res_valid`, `mem_rd` and `mem_wr` are 0.
- R2: A command is taken on a rising edge where `cmd_valid` and `cmd_ready` are both 1. The `cmd_op` codes are 0 bind, 1 empty test, 2 full test, 3 take, 4 store. Each taken command gives exactly one `res_valid` pulse, one cycle long, and `cmd_ready` stays low until that pulse. Codes 5 to 7 give a pulse with `res_flag`=1 and cause no bus request.
- R3: Binding with a nonzero base stores that base for the channel. In one bus tenure it then reads the mask from base-3, the in index from base-2 and the out index from base-1, with addresses wrapping modulo 2^ADDR_W. The result has `res_flag`=0.
- R4: The empty test reads the remote in index at base-2. `res_flag` is 1 exactly when that byte equals the local out copy.
- R5: The full test reads the remote out index at base-1. `res_flag` is 1 exactly when ((local in + 1) AND mask) equals that byte.
- R6: Take reads the byte at base + local out and returns it in `res_data` with `res_flag`=0. It writes (out + 1) AND mask to base-1 and keeps that value as the new local out.
- R7: Store writes `cmd_wdata` to base + local in. It writes (in + 1) AND mask to base-2 and keeps that value as the new local in. The result has `res_flag`=0.
- R8: While the ring is empty, take repeats the empty test, each time in a fresh bus tenure. It returns no result until the target advances the remote in index.
- R9: While the ring is full, store repeats the full test, each time in a fresh bus tenure. It completes once the target advances the remote out index.
- R10: On a channel whose stored base is zero, the empty and full tests return `res_flag`=1. Take and store are refused with `res_flag`=1 and change no memory. Neither these operations nor a bind to base zero raises `bus_req`.
- R11: `mem_rd` and `mem_wr` are raised only while both `bus_req` and `bus_gnt` are 1, and only one access is in flight at a time. After releasing the bus, the block waits for `bus_gnt` to fall before requesting again or answering. `bus_req` is 0 whenever `cmd_ready` is 1.
- R12: Each channel keeps its own base, mask and index copies. Operations on one channel leave the other channel's behaviour unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command will be taken |
| cmd_op | input | 3 | Operation code (see R2) |
| cmd_ch | input | CH_W (1) | Channel select |
| cmd_base | input | ADDR_W (19) | Base address for bind |
| cmd_wdata | input | DATA_W (8) | Byte for store |
| res_valid | output | 1 | One-cycle result pulse |
| res_flag | output | 1 | Test outcome, or refusal |
| res_data | output | DATA_W (8) | Byte returned by take |
| bus_req | output | 1 | Bus tenure request |
| bus_gnt | input | 1 | Bus tenure granted |
| mem_addr | output | ADDR_W (19) | Access address, held until acknowledge |
| mem_rd | output | 1 | Read strobe, held until acknowledge |
| mem_wr | output | 1 | Write strobe, held until acknowledge |
| mem_wdata | output | DATA_W (8) | Write byte |
| mem_rdata | input | DATA_W (8) | Read byte, sampled in the acknowledge cycle |
| mem_ack | input | 1 | Access complete |

## Verification
The assertions check on every cycle that the bus is used correctly. Strobes appear only inside a granted tenure, one access is in flight at a time, the bus is never requested while the block is idle, and results are single pulses. They also check that an unbound channel always answers its tests with 1. Only the bench scenarios can show the data path. That covers byte order through the ring, the index values written back to remote memory, and wrap at the mask boundary. It also covers take and store stalling until the target moves an index, and the two channels staying independent.

// File: rtl/rfc_pkg.sv
package rfc_pkg;

   typedef enum logic [2:0] {
      OP_INIT  = 3'd0,
      OP_EMPTY = 3'd1,
      OP_FULL  = 3'd2,
      OP_GET   = 3'd3,
      OP_PUT   = 3'd4
   } rfc_op_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ACQ,
      ST_ISSUE,
      ST_WAIT,
      ST_REL,
      ST_RESP
   } rfc_st_e;

endpackage

// File: rtl/rfc_desc_bank.sv
module rfc_desc_bank #(
   parameter int NUM_CH = 2,
   parameter int ADDR_W = 19,
   parameter int IDX_W  = 8,
   parameter int CH_W   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CH_W-1:0]   sel,
   input  logic              base_we,
   input  logic [ADDR_W-1:0] base_d,
   input  logic              mask_we,
   input  logic              in_we,
   input  logic              out_we,
   input  logic [IDX_W-1:0]  idx_d,
   output logic [ADDR_W-1:0] base_q,
   output logic [IDX_W-1:0]  mask_q,
   output logic [IDX_W-1:0]  in_q,
   output logic [IDX_W-1:0]  out_q
);

   logic [ADDR_W-1:0] base_a [NUM_CH];
   logic [IDX_W-1:0]  mask_a [NUM_CH];
   logic [IDX_W-1:0]  in_a   [NUM_CH];
   logic [IDX_W-1:0]  out_a  [NUM_CH];

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      logic              hit;
      logic [ADDR_W-1:0] base_r;
      logic [IDX_W-1:0]  mask_r, in_r, out_r;

      assign hit = (sel == CH_W'(g));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            base_r <= '0;
            mask_r <= '0;
            in_r   <= '0;
            out_r  <= '0;
         end else if (hit) begin
            if (base_we) base_r <= base_d;
            if (mask_we) mask_r <= idx_d;
            if (in_we)   in_r   <= idx_d;
            if (out_we)  out_r  <= idx_d;
         end
      end

      assign base_a[g] = base_r;
      assign mask_a[g] = mask_r;
      assign in_a[g]   = in_r;
      assign out_a[g]  = out_r;
   end

   if (NUM_CH == 1) begin : g_single
      assign base_q = base_a[0];
      assign mask_q = mask_a[0];
      assign in_q   = in_a[0];
      assign out_q  = out_a[0];
   end else begin : g_multi
      assign base_q = base_a[sel];
      assign mask_q = mask_a[sel];
      assign in_q   = in_a[sel];
      assign out_q  = out_a[sel];
   end

endmodule

// File: rtl/rfc_bus_engine.sv
module rfc_bus_engine #(
   parameter int ADDR_W = 19,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic [ADDR_W-1:0] go_addr,
   input  logic              go_we,
   input  logic [DATA_W-1:0] go_wdata,
   output logic              done,
   output logic [DATA_W-1:0] rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_ack
);

   logic              busy_q, we_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;

   // one strobe held from launch until acknowledge
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         we_q    <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
      end else if (go && !busy_q) begin
         busy_q  <= 1'b1;
         we_q    <= go_we;
         addr_q  <= go_addr;
         wdata_q <= go_wdata;
      end else if (busy_q && mem_ack) begin
         busy_q  <= 1'b0;
      end
   end

   assign mem_addr  = addr_q;
   assign mem_wdata = wdata_q;
   assign mem_rd    = busy_q & ~we_q;
   assign mem_wr    = busy_q &  we_q;
   assign done      = busy_q & mem_ack;
   assign rdata     = mem_rdata;

   AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      go |-> !busy_q) else $error("access launched while busy"); // R11

endmodule

// File: rtl/rfc_ring_client.sv
module rfc_ring_client
   import rfc_pkg::*;
#(
   parameter int ADDR_W = 19,
   parameter int DATA_W = 8,
   parameter int NUM_CH = 2,
   localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic [2:0]        cmd_op,
   input  logic [CH_W-1:0]   cmd_ch,
   input  logic [ADDR_W-1:0] cmd_base,
   input  logic [DATA_W-1:0] cmd_wdata,
   output logic              res_valid,
   output logic              res_flag,
   output logic [DATA_W-1:0] res_data,
   output logic              bus_req,
   input  logic              bus_gnt,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_ack
);

   if (ADDR_W < 4) begin : g_bad_addr
      $error("ADDR_W must be at least 4");
   end
   if (DATA_W < 2) begin : g_bad_data
      $error("DATA_W must be at least 2");
   end
   if (NUM_CH < 1) begin : g_bad_ch
      $error("NUM_CH must be at least 1");
   end

   rfc_st_e           st_q;
   rfc_op_e           op_q, cmd_op_e;
   logic [CH_W-1:0]   ch_q, sel;
   logic [DATA_W-1:0] wdata_q, data_q;
   logic [1:0]        step_q;
   logic              chk_q, fin_q, flag_q;

   logic [ADDR_W-1:0] cur_base;
   logic [DATA_W-1:0] cur_mask, cur_in, cur_out, nxt_in, nxt_out, idx_d;
   logic              base_we, mask_we, in_we, out_we, base_zero;

   logic              acc_go, acc_we, acc_done;
   logic [ADDR_W-1:0] acc_addr;
   logic [DATA_W-1:0] acc_wdata, acc_rdata;

   assign cmd_op_e  = rfc_op_e'(cmd_op);
   assign sel       = (st_q == ST_IDLE) ? cmd_ch : ch_q;
   assign base_zero = (cur_base == '0);
   assign nxt_in    = (cur_in  + DATA_W'(1)) & cur_mask;
   assign nxt_out   = (cur_out + DATA_W'(1)) & cur_mask;

   rfc_desc_bank #(
      .NUM_CH (NUM_CH),
      .ADDR_W (ADDR_W),
      .IDX_W  (DATA_W),
      .CH_W   (CH_W)
   ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel     (sel),
      .base_we (base_we),
      .base_d  (cmd_base),
      .mask_we (mask_we),
      .in_we   (in_we),
      .out_we  (out_we),
      .idx_d   (idx_d),
      .base_q  (cur_base),
      .mask_q  (cur_mask),
      .in_q    (cur_in),
      .out_q   (cur_out)
   );

   rfc_bus_engine #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .go        (acc_go),
      .go_addr   (acc_addr),
      .go_we     (acc_we),
      .go_wdata  (acc_wdata),
      .done      (acc_done),
      .rdata     (acc_rdata),
      .mem_addr  (mem_addr),
      .mem_rd    (mem_rd),
      .mem_wr    (mem_wr),
      .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata),
      .mem_ack   (mem_ack)
   );

   // access address, direction and write byte for the current step
   always_comb begin
      acc_addr = cur_base;
      unique case (op_q)
         OP_INIT:  acc_addr = cur_base - ADDR_W'(3) + ADDR_W'(step_q);
         OP_EMPTY: acc_addr = cur_base - ADDR_W'(2);
         OP_FULL:  acc_addr = cur_base - ADDR_W'(1);
         OP_GET:   acc_addr = chk_q ? cur_base - ADDR_W'(2) :
                              (step_q == 2'd0) ? cur_base + ADDR_W'(cur_out) :
                              cur_base - ADDR_W'(1);
         OP_PUT:   acc_addr = chk_q ? cur_base - ADDR_W'(1) :
                              (step_q == 2'd0) ? cur_base + ADDR_W'(cur_in) :
                              cur_base - ADDR_W'(2);
         default:  acc_addr = cur_base;
      endcase
   end

   assign acc_we    = !chk_q && (((op_q == OP_GET) && (step_q == 2'd1)) || (op_q == OP_PUT));
   assign acc_wdata = (op_q == OP_GET) ? nxt_out : ((step_q == 2'd0) ? wdata_q : nxt_in);
   assign acc_go    = (st_q == ST_ISSUE);

   // local descriptor updates
   always_comb begin
      base_we = (st_q == ST_IDLE) && cmd_valid && (cmd_op_e == OP_INIT);
      mask_we = 1'b0;
      in_we   = 1'b0;
      out_we  = 1'b0;
      idx_d   = acc_rdata;
      if ((st_q == ST_WAIT) && acc_done) begin
         unique case (op_q)
            OP_INIT: begin
               mask_we = (step_q == 2'd0);
               in_we   = (step_q == 2'd1);
               out_we  = (step_q == 2'd2);
            end
            OP_GET: if (!chk_q && step_q == 2'd1) begin
               out_we = 1'b1;
               idx_d  = nxt_out;
            end
            OP_PUT: if (!chk_q && step_q == 2'd1) begin
               in_we = 1'b1;
               idx_d = nxt_in;
            end
            default: ;
         endcase
      end
   end

   // operation sequencer
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         op_q    <= OP_INIT;
         ch_q    <= '0;
         wdata_q <= '0;
         data_q  <= '0;
         step_q  <= 2'd0;
         chk_q   <= 1'b0;
         fin_q   <= 1'b0;
         flag_q  <= 1'b0;
      end else begin
         unique case (st_q)
            ST_IDLE: if (cmd_valid) begin
               op_q    <= cmd_op_e;
               ch_q    <= cmd_ch;
               wdata_q <= cmd_wdata;
               data_q  <= '0;
               step_q  <= 2'd0;
               fin_q   <= 1'b0;
               flag_q  <= 1'b0;
               chk_q   <= 1'b0;
               unique case (cmd_op_e)
                  OP_INIT: st_q <= (cmd_base == '0) ? ST_RESP : ST_ACQ;
                  OP_EMPTY, OP_FULL, OP_GET, OP_PUT: begin
                     chk_q <= (cmd_op_e == OP_GET) || (cmd_op_e == OP_PUT);
                     if (base_zero) begin
                        flag_q <= 1'b1;
                        st_q   <= ST_RESP;
                     end else begin
                        st_q   <= ST_ACQ;
                     end
                  end
                  default: begin
                     flag_q <= 1'b1;
                     st_q   <= ST_RESP;
                  end
               endcase
            end
            ST_ACQ:   if (bus_gnt) st_q <= ST_ISSUE;
            ST_ISSUE: st_q <= ST_WAIT;
            ST_WAIT: if (acc_done) begin
               st_q <= ST_REL;
               unique case (op_q)
                  OP_INIT:
                     if (step_q != 2'd2) begin
                        step_q <= step_q + 2'd1;
                        st_q   <= ST_ISSUE;
                     end else begin
                        fin_q  <= 1'b1;
                     end
                  OP_EMPTY: begin
                     flag_q <= (acc_rdata == cur_out);
                     fin_q  <= 1'b1;
                  end
                  OP_FULL: begin
                     flag_q <= (acc_rdata == nxt_in);
                     fin_q  <= 1'b1;
                  end
                  OP_GET:
                     if (chk_q) begin
                        chk_q <= (acc_rdata == cur_out);
                     end else if (step_q == 2'd0) begin
                        data_q <= acc_rdata;
                        step_q <= 2'd1;
                        st_q   <= ST_ISSUE;
                     end else begin
                        fin_q  <= 1'b1;
                     end
                  OP_PUT:
                     if (chk_q) begin
                        chk_q <= (acc_rdata == nxt_in);
                     end else if (step_q == 2'd0) begin
                        step_q <= 2'd1;
                        st_q   <= ST_ISSUE;
                     end else begin
                        fin_q  <= 1'b1;
                     end
                  default: fin_q <= 1'b1;
               endcase
            end
            ST_REL: if (!bus_gnt) begin
               step_q <= 2'd0;
               st_q   <= fin_q ? ST_RESP : ST_ACQ;
            end
            ST_RESP: st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign cmd_ready = (st_q == ST_IDLE);
   assign bus_req   = (st_q == ST_ACQ) || (st_q == ST_ISSUE) || (st_q == ST_WAIT);
   assign res_valid = (st_q == ST_RESP);
   assign res_flag  = flag_q;
   assign res_data  = data_q;

   AST_STROBE_IN_TENURE: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd || mem_wr) |-> (bus_req && bus_gnt)) else $error("strobe outside tenure"); // R11

   AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ready |-> !bus_req) else $error("bus held while idle"); // R11

   AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid) else $error("result longer than one cycle"); // R2

   AST_UNBOUND_TEST: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && ((op_q == OP_EMPTY) || (op_q == OP_FULL)) && base_zero) |-> res_flag)
      else $error("unbound channel test not reported true"); // R10

endmodule

// File: tb/rfc_ring_client_bench.sv
module rfc_ring_client_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic        cmd_ready;
   logic [2:0]  cmd_op = 3'd0;
   logic [0:0]  cmd_ch = 1'b0;
   logic [18:0] cmd_base = '0;
   logic [7:0]  cmd_wdata = '0;
   logic        res_valid, res_flag;
   logic [7:0]  res_data;
   logic        bus_req;
   logic        bus_gnt = 1'b0;
   logic [18:0] mem_addr;
   logic        mem_rd, mem_wr;
   logic [7:0]  mem_wdata, mem_rdata;
   logic        mem_ack = 1'b0;

   always #5 clk = ~clk;

   rfc_ring_client u_rfc_ring_client (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
      .cmd_ch(cmd_ch), .cmd_base(cmd_base), .cmd_wdata(cmd_wdata),
      .res_valid(res_valid), .res_flag(res_flag), .res_data(res_data),
      .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_addr(mem_addr),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_ack(mem_ack)
   );

   // target memory and bus model
   logic [7:0] mem [0:1023];
   logic       req_prev = 1'b0;
   int         req_cnt = 0;

   assign mem_rdata = mem[mem_addr[9:0]];

   always @(posedge clk) begin
      bus_gnt  <= rst_n && bus_req;
      mem_ack  <= rst_n && (mem_rd || mem_wr) && !mem_ack && (($urandom % 3) != 0);
      if (mem_wr && mem_ack) mem[mem_addr[9:0]] <= mem_wdata;
      req_prev <= bus_req;
      if (bus_req && !req_prev) req_cnt <= req_cnt + 1;
   end

   int checks = 0;
   int errors = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // bench model
   logic [18:0] base_m [2];
   logic [7:0]  mask_m [2];
   logic [7:0]  in_m   [2];
   logic [7:0]  out_m  [2];
   logic [7:0]  q0 [$];
   logic [7:0]  q1 [$];

   function automatic logic [9:0] bi(input int ch, input int off);
      return base_m[ch][9:0] + 10'(off);
   endfunction

   function automatic bit m_empty(input int ch);
      return in_m[ch] == out_m[ch];
   endfunction

   function automatic bit m_full(input int ch);
      return ((in_m[ch] + 8'd1) & mask_m[ch]) == out_m[ch];
   endfunction

   task automatic run_cmd(input logic [2:0] op, input int ch, input logic [18:0] base,
                          input logic [7:0] wd, output logic flag, output logic [7:0] dat);
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_op    = op;
      cmd_ch    = 1'(ch);
      cmd_base  = base;
      cmd_wdata = wd;
      @(negedge clk);
      cmd_valid = 1'b0;
      while (!res_valid) @(negedge clk);
      flag = res_flag;
      dat  = res_data;
   endtask

   task automatic do_init(input int ch, input logic [18:0] base);
      logic f; logic [7:0] d; int rc;
      rc = req_cnt;
      base_m[ch] = base;
      run_cmd(3'd0, ch, base, 8'h00, f, d);
      mask_m[ch] = mem[bi(ch, -3)];
      in_m[ch]   = mem[bi(ch, -2)];
      out_m[ch]  = mem[bi(ch, -1)];
      chk(f == 1'b0, "R3", "bind flag", f, 0);
      chk(req_cnt - rc == 1, "R11", "bind tenures", req_cnt - rc, 1);
   endtask

   task automatic do_empty(input int ch);
      logic f; logic [7:0] d;
      run_cmd(3'd1, ch, 19'h0, 8'h00, f, d);
      chk(f == m_empty(ch), "R4", "empty flag", f, m_empty(ch));
   endtask

   task automatic do_full(input int ch);
      logic f; logic [7:0] d;
      run_cmd(3'd2, ch, 19'h0, 8'h00, f, d);
      chk(f == m_full(ch), "R5", "full flag", f, m_full(ch));
   endtask

   task automatic do_put(input int ch, input logic [7:0] v);
      logic f; logic [7:0] d, old, nw;
      old = in_m[ch];
      nw  = (old + 8'd1) & mask_m[ch];
      run_cmd(3'd4, ch, 19'h0, v, f, d);
      chk(f == 1'b0, "R7", "store flag", f, 0);
      chk(mem[bi(ch, int'(old))] == v, "R7", "stored byte", mem[bi(ch, int'(old))], v);
      chk(mem[bi(ch, -2)] == nw, "R7", "remote in index", mem[bi(ch, -2)], nw);
      in_m[ch] = nw;
      if (ch == 0) q0.push_back(v); else q1.push_back(v);
   endtask

   task automatic do_get(input int ch);
      logic f; logic [7:0] d, e, nw;
      e  = (ch == 0) ? q0.pop_front() : q1.pop_front();
      nw = (out_m[ch] + 8'd1) & mask_m[ch];
      run_cmd(3'd3, ch, 19'h0, 8'h00, f, d);
      chk(f == 1'b0, "R6", "take flag", f, 0);
      chk(d == e, "R6", "take byte", d, e);
      chk(mem[bi(ch, -1)] == nw, "R6", "remote out index", mem[bi(ch, -1)], nw);
      out_m[ch] = nw;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL R2 watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      logic f; logic [7:0] d; int rc; bit got;
      void'($urandom(32'd2718));
      for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
      // channel 0: base 0x00100, mask 7, in = out = 3
      mem[10'h0FD] = 8'd7; mem[10'h0FE] = 8'd3; mem[10'h0FF] = 8'd3;
      // channel 1: base 0x40200 (upper address bits set), mask 3, in = out = 2
      mem[10'h1FD] = 8'd3; mem[10'h1FE] = 8'd2; mem[10'h1FF] = 8'd2;

      repeat (3) @(negedge clk);
      chk(cmd_ready && !bus_req && !res_valid && !mem_rd && !mem_wr, "R1",
          "outputs in reset", {cmd_ready, bus_req, res_valid, mem_rd, mem_wr}, 5'b10000);
      rst_n = 1'b1;
      @(negedge clk);
      chk(cmd_ready && !bus_req && !res_valid, "R1", "outputs after reset",
          {cmd_ready, bus_req, res_valid}, 3'b100);

      // unbound channel
      rc = req_cnt;
      run_cmd(3'd1, 0, 19'h0, 8'h00, f, d);
      chk(f == 1'b1, "R10", "unbound empty", f, 1);
      run_cmd(3'd2, 0, 19'h0, 8'h00, f, d);
      chk(f == 1'b1, "R10", "unbound full", f, 1);
      run_cmd(3'd3, 0, 19'h0, 8'h00, f, d);
      chk(f == 1'b1, "R10", "unbound take refused", f, 1);
      run_cmd(3'd4, 0, 19'h0, 8'h77, f, d);
      chk(f == 1'b1, "R10", "unbound store refused", f, 1);
      chk(mem[0] == 8'h00, "R10", "unbound store memory", mem[0], 0);
      run_cmd(3'd0, 1, 19'h0, 8'h00, f, d);
      chk(f == 1'b0, "R10", "bind zero flag", f, 0);
      run_cmd(3'd5, 0, 19'h0, 8'h00, f, d);
      chk(f == 1'b1, "R2", "unknown op refused", f, 1);
      chk(req_cnt == rc, "R10", "no tenure while unbound", req_cnt - rc, 0);

      do_init(0, 19'h00100);
      chk(mask_m[0] == 8'd7, "R3", "mask seen", mask_m[0], 7);
      do_empty(0);
      do_full(0);
      do_init(1, 19'h40200);

      // fill channel 0 to capacity, index wraps 7 -> 0
      for (int i = 0; i < 7; i++) do_put(0, 8'hA0 + 8'(i));
      do_full(0);
      do_empty(0);
      do_empty(1);   // R12: channel 1 unaffected by channel 0 traffic
      chk(mem[10'h1FE] == 8'd2, "R12", "channel 1 in untouched", mem[10'h1FE], 2);
      for (int i = 0; i < 7; i++) do_get(0);
      do_empty(0);

      // take stalls on empty channel 1 until target produces
      got = 0; rc = req_cnt;
      fork
         begin
            run_cmd(3'd3, 1, 19'h0, 8'h00, f, d);
            got = 1;
         end
         begin
            repeat (40) @(negedge clk);
            chk(!got && !cmd_ready, "R8", "take stalled", got, 0);
            chk(req_cnt - rc >= 2, "R8", "repeated poll tenures", req_cnt - rc, 2);
            mem[10'h202] = 8'h5C;
            mem[10'h1FE] = 8'd3;
         end
      join
      chk(d == 8'h5C && f == 1'b0, "R8", "stalled take byte", d, 8'h5C);
      chk(mem[10'h1FF] == 8'd3, "R8", "stalled take out index", mem[10'h1FF], 3);
      do_init(1, 19'h40200);

      // store stalls on full channel 1 until target consumes
      for (int i = 0; i < 3; i++) do_put(1, 8'h11 * 8'(i + 1));
      do_full(1);
      got = 0;
      fork
         begin
            run_cmd(3'd4, 1, 19'h0, 8'h44, f, d);
            got = 1;
         end
         begin
            repeat (40) @(negedge clk);
            chk(!got && !cmd_ready, "R9", "store stalled", got, 0);
            chk(mem[10'h203] == 8'h11, "R9", "oldest byte", mem[10'h203], 8'h11);
            void'(q1.pop_front());
            out_m[1] = 8'd0;
            mem[10'h1FF] = 8'd0;
         end
      join
      chk(f == 1'b0 && mem[10'h202] == 8'h44, "R9", "stalled store byte", mem[10'h202], 8'h44);
      chk(mem[10'h1FE] == 8'd3, "R9", "stalled store in index", mem[10'h1FE], 3);
      q1.push_back(8'h44);
      in_m[1] = 8'd3;
      do_init(1, 19'h40200);
      do_get(1);

      // constrained random loopback traffic on both channels
      for (int n = 0; n < 300; n++) begin
         int ch, k;
         ch = int'($urandom % 2);
         k  = int'($urandom % 4);
         if (k == 0) begin
            if (m_full(ch)) do_full(ch); else do_put(ch, 8'($urandom));
         end else if (k == 1) begin
            if (m_empty(ch)) do_empty(ch); else do_get(ch);
         end else if (k == 2) begin
            do_empty(ch);
         end else begin
            do_full(ch);
         end
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule